// File: doc/BRIEF.md
# USB Endpoint Handshake Response Selector

This block keeps the control state of a single USB device endpoint and chooses the handshake that the device returns when the host addresses that endpoint with a token. The application side writes the endpoint type, the transmit queue index and the snoop option through one write port. Single-cycle strobes set and clear the endpoint's STALL and NAK flags. Two level inputs carry the chip-wide "NAK every IN" and "NAK every OUT" conditions.

The token side presents a token code together with a valid strobe, a queue-ready flag and a packet-integrity flag. One cycle later the block returns a handshake code. It also returns a transfer-go pulse, which tells the surrounding logic to forward received data or to start sending IN data. STALL outranks every NAK source. A SETUP packet that arrives intact is always acknowledged. On a control endpoint, a SETUP token releases STALL in hardware. Isochronous endpoints never produce a handshake.

Top module: `ep_hs_select`

## Requirements
- R1: After a synchronous reset every stored field reads 0 (type, queue index, snoop, STALL, NAK), and hs_valid is 0 with hs_code 0.
- R2: Token codes are 01 OUT, 10 IN and 11 SETUP. Handshake codes are 00 none, 01 ACK, 10 NAK and 11 STALL. The response appears on hs_valid, hs_code and xfer_go in the cycle after the one in which tok_valid is high, and lasts one cycle. The decision uses the stored state from before that edge. A token code of 00 produces no response (hs_valid stays 0). When hs_valid is 0, hs_code is 00 and xfer_go is 0.
- R3: On a non-isochronous endpoint with STALL set, an IN token or an intact OUT packet is answered with STALL (11), even if the local NAK, the global IN NAK or the global OUT NAK is also active.
- R4: An intact SETUP packet (pkt_ok=1) is answered with ACK and xfer_go=1, whatever the STALL and NAK settings. A corrupt SETUP packet gets no handshake.
- R5: On a control endpoint (type 00), any SETUP token clears STALL at the same edge. If stall_set is high in that same cycle, STALL stays set.
- R6: On any endpoint type other than control, STALL is cleared only by stall_clr. When stall_set and stall_clr are high together, stall_set wins.
- R7: nak_set sets and nak_clr clears the endpoint NAK flag, and set wins when both are high. On a non-isochronous endpoint without STALL, local NAK forces NAK (10) for IN tokens and for intact OUT packets. The global IN NAK does this for IN tokens only, and the global OUT NAK for OUT tokens only.
- R8: On a non-isochronous endpoint with no STALL and no NAK source active:
  - an intact OUT packet gets ACK with xfer_go=1 when fifo_rdy=1, and NAK when fifo_rdy=0;
  - an IN token with fifo_rdy=1 gets code 00 with xfer_go=1, because data is sent instead of a handshake;
  - an IN token with fifo_rdy=0 gets NAK.
- R9: A corrupt OUT packet (pkt_ok=0) gets no handshake and no xfer_go, and this outranks STALL, unless snoop is set, in which case the packet counts as intact. Snoop has no effect on SETUP packets.
- R10: On an isochronous endpoint (type 01), IN and OUT tokens always get code 00, and STALL and NAK have no effect. xfer_go is fifo_rdy for IN tokens, and fifo_rdy with an intact (or snooped) packet for OUT tokens.
- R11: A cycle with cfg_we=1 loads the type, the 4-bit queue index and the snoop option, which then read back unchanged on st_kind, st_fifo_num and st_snoop from the next cycle. Index 0 means the shared non-periodic queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load type, queue index and snoop |
| cfg_kind | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| cfg_fifo_num | input | FIFO_W | Transmit queue index (0 is the non-periodic queue) |
| cfg_snoop | input | 1 | Accept OUT packets without checking integrity |
| stall_set | input | 1 | Set STALL |
| stall_clr | input | 1 | Clear STALL |
| nak_set | input | 1 | Set endpoint NAK |
| nak_clr | input | 1 | Clear endpoint NAK |
| gin_nak | input | 1 | Global NAK for IN tokens |
| gout_nak | input | 1 | Global NAK for OUT tokens |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | Token code: 01 OUT, 10 IN, 11 SETUP |
| fifo_rdy | input | 1 | Queue can accept or supply a packet |
| pkt_ok | input | 1 | Received data packet is intact |
| hs_valid | output | 1 | Response valid |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| xfer_go | output | 1 | Forward OUT or SETUP data, or start IN data |
| st_kind | output | 2 | Stored endpoint type |
| st_fifo_num | output | FIFO_W | Stored queue index |
| st_snoop | output | 1 | Stored snoop option |
| st_stall | output | 1 | STALL flag |
| st_nak | output | 1 | Endpoint NAK flag |

## Verification
The properties assume that tok_kind, fifo_rdy and pkt_ok matter only in a cycle where tok_valid is high, and that each token is a single-cycle strobe. They also assume the global NAK inputs are levels. The priority properties compare the response against the stored status outputs sampled in the token cycle, so they allow strobes to change that state at the same edge. The stimulus sets up the endpoint, then leaves the strobes low while the token is presented. The only exceptions are the directed same-cycle cases, which test that ordering on purpose.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        EK_CTRL = 2'b00,
        EK_ISO  = 2'b01,
        EK_BULK = 2'b10,
        EK_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'b00,
        TK_OUT   = 2'b01,
        TK_IN    = 2'b10,
        TK_SETUP = 2'b11
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef struct packed {
        ep_kind_e kind;
        logic     stall;
        logic     nak;
        logic     snoop;
    } ep_state_t;

    typedef struct packed {
        logic valid;
        hs_e  code;
        logic go;
    } hs_res_t;

    // Data integrity as seen by the decision: snoop only bypasses checks on OUT data
    function automatic logic data_good(tok_e t, logic pkt_ok, logic snoop);
        return (t == TK_OUT) ? (pkt_ok | snoop) : pkt_ok;
    endfunction

    // NAK sources that apply to a given token direction
    function automatic logic nak_active(tok_e t, logic local_nak, logic gin, logic gout);
        return local_nak | ((t == TK_IN) & gin) | ((t == TK_OUT) & gout);
    endfunction

endpackage

// File: rtl/ep_ctrl_regs.sv
module ep_ctrl_regs
    import ep_hs_pkg::*;
#(
    parameter int FIFO_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [FIFO_W-1:0] cfg_fifo_num,
    input  logic              cfg_snoop,
    input  logic              stall_set,
    input  logic              stall_clr,
    input  logic              nak_set,
    input  logic              nak_clr,
    input  logic              setup_seen,
    output ep_state_t         state,
    output logic [FIFO_W-1:0] fifo_num
);

    logic hw_stall_release;

    // Control endpoints drop STALL on a SETUP token
    assign hw_stall_release = setup_seen && (state.kind == EK_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= '0;
            fifo_num <= '0;
        end else begin
            if (cfg_we) begin
                state.kind  <= ep_kind_e'(cfg_kind);
                state.snoop <= cfg_snoop;
                fifo_num    <= cfg_fifo_num;
            end
            if (stall_set)
                state.stall <= 1'b1;
            else if (stall_clr || hw_stall_release)
                state.stall <= 1'b0;
            if (nak_set)
                state.nak <= 1'b1;
            else if (nak_clr)
                state.nak <= 1'b0;
        end
    end

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import ep_hs_pkg::*;
(
    input  ep_state_t state,
    input  logic      tok_valid,
    input  tok_e      tok,
    input  logic      fifo_rdy,
    input  logic      pkt_ok,
    input  logic      gin_nak,
    input  logic      gout_nak,
    output hs_res_t   res
);

    logic good;
    logic nak_eff;

    always_comb begin
        good    = data_good(tok, pkt_ok, state.snoop);
        nak_eff = nak_active(tok, state.nak, gin_nak, gout_nak);
        res     = '{valid: 1'b0, code: HS_NONE, go: 1'b0};
        if (tok_valid && tok != TK_NONE) begin
            res.valid = 1'b1;
            if (tok == TK_SETUP) begin
                if (good) begin
                    res.code = HS_ACK;
                    res.go   = 1'b1;
                end
            end else if (state.kind == EK_ISO) begin
                res.go = fifo_rdy & ((tok == TK_IN) | good);
            end else if (tok == TK_OUT && !good) begin
                res.code = HS_NONE;
            end else if (state.stall) begin
                res.code = HS_STALL;
            end else if (nak_eff || !fifo_rdy) begin
                res.code = HS_NAK;
            end else if (tok == TK_OUT) begin
                res.code = HS_ACK;
                res.go   = 1'b1;
            end else begin
                res.go = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ep_hs_select.sv
module ep_hs_select
    import ep_hs_pkg::*;
#(
    parameter int FIFO_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [FIFO_W-1:0] cfg_fifo_num,
    input  logic              cfg_snoop,
    input  logic              stall_set,
    input  logic              stall_clr,
    input  logic              nak_set,
    input  logic              nak_clr,
    input  logic              gin_nak,
    input  logic              gout_nak,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic              fifo_rdy,
    input  logic              pkt_ok,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              xfer_go,
    output logic [1:0]        st_kind,
    output logic [FIFO_W-1:0] st_fifo_num,
    output logic              st_snoop,
    output logic              st_stall,
    output logic              st_nak
);

    tok_e      tok;
    ep_state_t state;
    hs_res_t   res_d;
    hs_res_t   res_q;
    logic      setup_seen;

    assign tok        = tok_e'(tok_kind);
    assign setup_seen = tok_valid && (tok == TK_SETUP);

    ep_ctrl_regs #(.FIFO_W(FIFO_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_kind     (cfg_kind),
        .cfg_fifo_num (cfg_fifo_num),
        .cfg_snoop    (cfg_snoop),
        .stall_set    (stall_set),
        .stall_clr    (stall_clr),
        .nak_set      (nak_set),
        .nak_clr      (nak_clr),
        .setup_seen   (setup_seen),
        .state        (state),
        .fifo_num     (st_fifo_num)
    );

    ep_hs_decide u_dec (
        .state     (state),
        .tok_valid (tok_valid),
        .tok       (tok),
        .fifo_rdy  (fifo_rdy),
        .pkt_ok    (pkt_ok),
        .gin_nak   (gin_nak),
        .gout_nak  (gout_nak),
        .res       (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign hs_valid = res_q.valid;
    assign hs_code  = res_q.code;
    assign xfer_go  = res_q.go;
    assign st_kind  = state.kind;
    assign st_snoop = state.snoop;
    assign st_stall = state.stall;
    assign st_nak   = state.nak;

endmodule

// File: rtl/ep_hs_chk.sv
module ep_hs_chk
    import ep_hs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stall_set,
    input logic       stall_clr,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       pkt_ok,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       xfer_go,
    input logic [1:0] st_kind,
    input logic       st_snoop,
    input logic       st_stall,
    input logic       st_nak
);

    logic data_in;
    assign data_in = (tok_kind == TK_IN) || (tok_kind == TK_OUT && (pkt_ok || st_snoop));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !tok_valid |=> !hs_valid);

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (rst)
        !hs_valid |-> (hs_code == HS_NONE && !xfer_go));

    assert_stall_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && data_in && st_kind != EK_ISO && st_stall) |=> (hs_valid && hs_code == HS_STALL));

    assert_setup_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_SETUP && pkt_ok) |=> (hs_code == HS_ACK && xfer_go));

    assert_ctrl_release_R5: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_SETUP && st_kind == EK_CTRL && !stall_set) |=> !st_stall);

    assert_stall_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (st_stall && st_kind != EK_CTRL && !stall_clr) |=> st_stall);

    assert_nak_forced_R7: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && data_in && st_nak && !st_stall && st_kind != EK_ISO) |=> (hs_code == HS_NAK));

    assert_iso_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && st_kind == EK_ISO && tok_kind != TK_SETUP) |=> (hs_code == HS_NONE));

endmodule

bind ep_hs_select ep_hs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall_set (stall_set),
    .stall_clr (stall_clr),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .pkt_ok    (pkt_ok),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .xfer_go   (xfer_go),
    .st_kind   (st_kind),
    .st_snoop  (st_snoop),
    .st_stall  (st_stall),
    .st_nak    (st_nak)
);

// File: tb/sim_ep_hs_select.sv
`timescale 1ns/1ps
module sim_ep_hs_select;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, cfg_snoop, stall_set, stall_clr, nak_set, nak_clr;
    logic       gin_nak, gout_nak, tok_valid, fifo_rdy, pkt_ok;
    logic [1:0] cfg_kind, tok_kind;
    logic [3:0] cfg_fifo_num;
    logic       hs_valid, xfer_go, st_snoop, st_stall, st_nak;
    logic [1:0] hs_code, st_kind;
    logic [3:0] st_fifo_num;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ep_hs_select u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_fifo_num(cfg_fifo_num), .cfg_snoop(cfg_snoop),
        .stall_set(stall_set), .stall_clr(stall_clr),
        .nak_set(nak_set), .nak_clr(nak_clr),
        .gin_nak(gin_nak), .gout_nak(gout_nak),
        .tok_valid(tok_valid), .tok_kind(tok_kind),
        .fifo_rdy(fifo_rdy), .pkt_ok(pkt_ok),
        .hs_valid(hs_valid), .hs_code(hs_code), .xfer_go(xfer_go),
        .st_kind(st_kind), .st_fifo_num(st_fifo_num), .st_snoop(st_snoop),
        .st_stall(st_stall), .st_nak(st_nak)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic       stall, nak, gin, gout, snoop;
        logic [1:0] tok;
        logic       rdy, ok;
        logic [1:0] code;
        logic       go;
    } vec_t;

    localparam int NV = 22;
    // kind stall nak gin gout snoop tok rdy ok | code go
    localparam vec_t VECS [NV] = '{
        16'b10_0_0_0_0_0_01_1_1_01_1, // R8 OUT ready -> ACK
        16'b10_0_0_0_0_0_01_0_1_10_0, // R8 OUT not ready -> NAK
        16'b10_0_0_0_0_0_10_1_0_00_1, // R8 IN ready -> data
        16'b10_0_0_0_0_0_10_0_0_10_0, // R8 IN empty -> NAK
        16'b10_1_1_0_0_0_01_1_1_11_0, // R3 STALL over local NAK
        16'b10_1_0_1_0_0_10_1_0_11_0, // R3 STALL over global IN NAK
        16'b11_1_0_0_1_0_01_1_1_11_0, // R3 STALL over global OUT NAK
        16'b10_0_1_0_0_0_10_1_0_10_0, // R7 local NAK on IN
        16'b10_0_0_1_0_0_10_1_0_10_0, // R7 global IN NAK on IN
        16'b10_0_0_1_0_0_01_1_1_01_1, // R7 global IN NAK ignored on OUT
        16'b10_0_0_0_1_0_01_1_1_10_0, // R7 global OUT NAK on OUT
        16'b10_0_0_0_1_0_10_1_0_00_1, // R7 global OUT NAK ignored on IN
        16'b10_0_0_0_0_0_01_1_0_00_0, // R9 corrupt OUT dropped
        16'b10_0_0_0_0_1_01_1_0_01_1, // R9 snoop accepts corrupt OUT
        16'b10_1_0_0_0_0_01_1_0_00_0, // R9 corrupt OUT beats STALL
        16'b00_1_1_0_0_0_11_0_1_01_1, // R4 SETUP ACK despite STALL/NAK
        16'b00_0_0_0_0_0_11_1_0_00_0, // R4 corrupt SETUP silent
        16'b01_1_0_0_0_0_01_1_1_00_1, // R10 iso OUT, STALL ignored
        16'b01_0_1_0_0_0_10_1_0_00_1, // R10 iso IN, NAK ignored
        16'b01_0_0_0_0_0_10_0_0_00_0, // R10 iso IN not ready
        16'b00_1_0_0_0_0_10_1_0_11_0, // R3 control IN stalled
        16'b10_0_0_0_0_1_11_1_0_00_0  // R9 snoop ignored for SETUP
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_kind = 0; cfg_fifo_num = 0; cfg_snoop = 0;
        stall_set = 0; stall_clr = 0; nak_set = 0; nak_clr = 0;
        gin_nak = 0; gout_nak = 0; tok_valid = 0; tok_kind = 0;
        fifo_rdy = 0; pkt_ok = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic config_ep(input logic [1:0] k, input logic sn);
        cfg_we = 1; cfg_kind = k; cfg_snoop = sn;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send_tok(input logic [1:0] t, input logic rdy, input logic ok);
        tok_valid = 1; tok_kind = t; fifo_rdy = rdy; pkt_ok = ok;
        @(negedge clk);
        tok_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 st_kind", st_kind, 0);
        check("R1 st_fifo_num", st_fifo_num, 0);
        check("R1 st_stall", st_stall, 0);
        check("R1 st_nak", st_nak, 0);
        check("R1 st_snoop", st_snoop, 0);
        check("R1 hs_valid", hs_valid, 0);
        check("R1 hs_code", hs_code, 0);

        // R11 configuration readback
        cfg_we = 1; cfg_kind = 2'b11; cfg_fifo_num = 4'hA; cfg_snoop = 1;
        @(negedge clk);
        cfg_we = 0; cfg_kind = 0; cfg_fifo_num = 0; cfg_snoop = 0;
        check("R11 st_kind", st_kind, 3);
        check("R11 st_fifo_num", st_fifo_num, 10);
        check("R11 st_snoop", st_snoop, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            cfg_we = 1; cfg_kind = VECS[i].kind; cfg_snoop = VECS[i].snoop;
            stall_set = VECS[i].stall; nak_set = VECS[i].nak;
            gin_nak = VECS[i].gin; gout_nak = VECS[i].gout;
            @(negedge clk);
            cfg_we = 0; stall_set = 0; nak_set = 0;
            send_tok(VECS[i].tok, VECS[i].rdy, VECS[i].ok);
            check($sformatf("R2 vec%0d hs_valid", i), hs_valid, 1);
            check($sformatf("R3/R4/R7/R8/R9/R10 vec%0d hs_code", i), hs_code, VECS[i].code);
            check($sformatf("R8/R10 vec%0d xfer_go", i), xfer_go, VECS[i].go);
        end

        // R2 response lasts one cycle; reserved token code gives nothing
        do_reset();
        config_ep(2'b10, 0);
        send_tok(2'b01, 1, 1);
        check("R2 response present", hs_valid, 1);
        @(negedge clk);
        check("R2 response one cycle", hs_valid, 0);
        check("R2 idle code", hs_code, 0);
        send_tok(2'b00, 1, 1);
        check("R2 reserved token", hs_valid, 0);

        // R2 decision uses state from before the edge
        nak_set = 1;
        send_tok(2'b01, 1, 1);
        nak_set = 0;
        check("R2 old-state decision", hs_code, 1);
        check("R7 nak_set", st_nak, 1);
        nak_clr = 1;
        @(negedge clk);
        nak_clr = 0;
        check("R7 nak_clr", st_nak, 0);
        send_tok(2'b01, 1, 1);
        check("R7 ACK after clear", hs_code, 1);
        nak_set = 1; nak_clr = 1;
        @(negedge clk);
        nak_set = 0; nak_clr = 0;
        check("R7 set wins", st_nak, 1);

        // R5 control endpoint: SETUP releases STALL
        do_reset();
        config_ep(2'b00, 0);
        stall_set = 1;
        @(negedge clk);
        stall_set = 0;
        check("R5 stall set", st_stall, 1);
        send_tok(2'b11, 1, 0);
        check("R5 SETUP clears stall", st_stall, 0);
        stall_set = 1;
        send_tok(2'b11, 1, 1);
        stall_set = 0;
        check("R5 set beats SETUP clear", st_stall, 1);

        // R6 bulk endpoint: SETUP does not release STALL
        do_reset();
        config_ep(2'b10, 0);
        stall_set = 1;
        @(negedge clk);
        stall_set = 0;
        send_tok(2'b11, 1, 1);
        check("R6 SETUP keeps stall", st_stall, 1);
        send_tok(2'b10, 1, 0);
        check("R6 still stalling", hs_code, 3);
        stall_set = 1; stall_clr = 1;
        @(negedge clk);
        stall_set = 0;
        check("R6 set beats clear", st_stall, 1);
        @(negedge clk);
        stall_clr = 0;
        check("R6 clear", st_stall, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule